// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets clocked logic use an external asynchronous static RAM of 131,072 bytes. A requester presents one read or write request at a time with a valid/ready handshake: a 17-bit word address, a write flag and 8 bits of write data. The controller turns each accepted request into a timed sequence on the memory's active-low chip-enable, write-enable and output-enable strobes. It drives the shared data bus through separate out, out-enable and in signals. Read data returns on a one-cycle valid pulse.

The length of each phase is a clock-cycle count given as a parameter. The integrator rounds each nanosecond limit of the chosen speed grade up to whole cycles of the system clock. A read holds the strobes active for the access time. A write uses one setup cycle followed by a write-enable pulse long enough for both the minimum pulse width and the data-to-end-of-write window. The memory's outputs take time to release the bus after a read, so one idle turnaround cycle follows every read before the controller may drive the bus again.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, the chip-enable, write-enable and output-enable strobes are all high, the data drivers are off, `req_ready` is high and `rd_valid` is low.
- R2: A read holds chip-enable and output-enable low with write-enable high for exactly TAA_CYC consecutive cycles. Output-enable is never low unless chip-enable is low and write-enable is high.
- R3: A write holds write-enable low for exactly max(TWP_CYC, TDW_CYC) consecutive cycles. It is preceded by one cycle with chip-enable low and write-enable high. The memory then holds the written byte.
- R4: Output-enable stays high in every cycle in which write-enable is low or the data drivers are on.
- R5: The memory address changes only on a clock edge before which chip-enable and write-enable were both high, and after which write-enable is still high.
- R6: While write-enable is low, the driven data and the address hold steady, and the data equals the accepted write data.
- R7: The data drivers turn on only when output-enable has been high for at least the two preceding cycles.
- R8: `req_ready` is high only in the idle state and drops on the edge that accepts a request. It stays low for TAA_CYC+1 cycles after a read and max(TWP_CYC, TDW_CYC)+1 cycles after a write. Request fields that change while `req_ready` is low have no effect on the address or the data.
- R9: `rd_valid` pulses high for exactly one cycle, TAA_CYC cycles after the cycle following acceptance of a read. `rd_data` carries the byte the memory drove at the end of the access wait. Writes never raise `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | 8 | Returned read data |
| sram_addr | output | 17 | Memory address lines |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq_out | output | 8 | Data the controller drives onto the bus |
| sram_dq_oe | output | 1 | Enable for the controller's bus drivers |
| sram_dq_in | input | 8 | Data sampled from the bus |

## Verification
Two things can fall in the same cycle. A write can end by releasing its strobes, and the next request can be accepted in the first idle cycle, which changes the address on the very next edge. A read can also release the bus while a following write is already waiting to drive it. The bench keeps `req_valid` high from one request to the next, so each new request is taken in the first idle cycle, and mixes random reads and writes to a small set of addresses. A negedge monitor compares each address change and each driver turn-on with the strobe history of the cycles before it. Read-back against a reference map confirms that no write was lost or misplaced at those boundaries.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    localparam int unsigned SRAM_ADDR_W = 17;
    localparam int unsigned SRAM_DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_READ_WAIT   = 3'd1,
        ST_WRITE_SETUP = 3'd2,
        ST_WRITE_PULSE = 3'd3,
        ST_TURNAROUND  = 3'd4
    } ctrl_state_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic drive;
    } strobe_t;

    localparam strobe_t STROBE_QUIET = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

    function automatic strobe_t strobes_for(ctrl_state_e s);
        strobe_t v;
        v = STROBE_QUIET;
        case (s)
            ST_READ_WAIT: begin
                v.ce_n = 1'b0;
                v.oe_n = 1'b0;
            end
            ST_WRITE_SETUP: begin
                v.ce_n  = 1'b0;
                v.drive = 1'b1;
            end
            ST_WRITE_PULSE: begin
                v.ce_n  = 1'b0;
                v.we_n  = 1'b0;
                v.drive = 1'b1;
            end
            default: v = STROBE_QUIET;
        endcase
        return v;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned TAA_CYC   = 2,
    parameter int unsigned PULSE_CYC = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    output ctrl_state_e state_q,
    output ctrl_state_e state_d,
    output logic        accept,
    output logic        capture
);
    localparam int unsigned CNT_MAX = max_u(TAA_CYC, PULSE_CYC);
    localparam int unsigned CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);

    logic [CNT_W-1:0] cnt_q, cnt_d;

    assign accept = (state_q == ST_IDLE) && req_valid;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        capture = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_write) begin
                        state_d = ST_WRITE_SETUP;
                    end else begin
                        state_d = ST_READ_WAIT;
                        cnt_d   = CNT_W'(TAA_CYC - 1);
                    end
                end
            end
            ST_READ_WAIT: begin
                if (cnt_q == '0) begin
                    state_d = ST_TURNAROUND;
                    capture = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_WRITE_SETUP: begin
                state_d = ST_WRITE_PULSE;
                cnt_d   = CNT_W'(PULSE_CYC - 1);
            end
            ST_WRITE_PULSE: begin
                if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_TURNAROUND: state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end
endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen
    import sram_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  ctrl_state_e state_d,
    output strobe_t     strobes
);
    always_ff @(posedge clk) begin
        if (rst) begin
            strobes <= STROBE_QUIET;
        end else begin
            strobes <= strobes_for(state_d);
        end
    end
endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              rvalid_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= capture;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) begin
                rdata_q <= bus_in;
            end
        end
    end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W  = SRAM_ADDR_W,
    parameter int unsigned DATA_W  = SRAM_DATA_W,
    parameter int unsigned TAA_CYC = 2,
    parameter int unsigned TWP_CYC = 2,
    parameter int unsigned TDW_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    localparam int unsigned PULSE_CYC = max_u(TWP_CYC, TDW_CYC);

    ctrl_state_e state_q, state_d;
    logic        accept, capture;
    strobe_t     strobes;

    sram_ctrl_fsm #(.TAA_CYC(TAA_CYC), .PULSE_CYC(PULSE_CYC)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .state_q   (state_q),
        .state_d   (state_d),
        .accept    (accept),
        .capture   (capture)
    );

    sram_strobe_gen u_strb (
        .clk     (clk),
        .rst     (rst),
        .state_d (state_d),
        .strobes (strobes)
    );

    sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bus_in    (sram_dq_in),
        .addr_q    (sram_addr),
        .wdata_q   (sram_dq_out),
        .rdata_q   (rd_data),
        .rvalid_q  (rd_valid)
    );

    assign req_ready  = (state_q == ST_IDLE);
    assign sram_ce_n  = strobes.ce_n;
    assign sram_we_n  = strobes.we_n;
    assign sram_oe_n  = strobes.oe_n;
    assign sram_dq_oe = strobes.drive;
endmodule

// File: rtl/sram_async_ctrl_checker.sv
module sram_async_ctrl_checker #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_ce_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic [DATA_W-1:0] sram_dq_out,
    input logic              sram_dq_oe
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe && !rd_valid));

    assert_read_strobes_R2: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> (!sram_ce_n && sram_we_n));

    assert_write_setup_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(sram_we_n) |-> $past(!sram_ce_n && sram_we_n));

    assert_no_fight_R4: assert property (@(posedge clk) disable iff (rst)
        (!sram_we_n || sram_dq_oe) |-> sram_oe_n);

    assert_addr_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(sram_addr) |-> ($past(sram_ce_n) && $past(sram_we_n) && sram_we_n));

    assert_write_steady_R6: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> ($stable(sram_dq_out) && $stable(sram_addr)));

    assert_turnaround_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_dq_oe) |-> ($past(sram_oe_n) && $past(sram_oe_n, 2)));

    assert_ready_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_rd_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    assert_write_no_rdata_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_write) |=> (!rd_valid && $past(1'b1)));
endmodule

bind sram_async_ctrl sram_async_ctrl_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sram_async_ctrl_test.sv
module sram_async_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int TAA = 3;
    localparam int TWP = 2;
    localparam int TDW = 3;
    localparam int PULSE = (TWP > TDW) ? TWP : TDW;
    localparam logic [7:0] BLANK = 8'hA5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr  = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rd_valid;
    logic [7:0]  rd_data;
    logic [16:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [7:0]  sram_dq_out;
    logic [7:0]  sram_dq_in = 8'hEE;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [7:0] model_mem [int];
    logic [7:0] ref_mem   [int];
    logic [7:0] exp_q [$];
    int         acc_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_async_ctrl #(.TAA_CYC(TAA), .TWP_CYC(TWP), .TDW_CYC(TDW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .sram_addr(sram_addr),
        .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] expect_at(logic [16:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : BLANK;
    endfunction

    // behavioural memory: writes during CE/WE overlap, drives bus on a read
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!sram_ce_n && !sram_we_n && sram_dq_oe)
            model_mem[int'(sram_addr)] = sram_dq_out;
    end

    always @(negedge clk) begin
        if (!sram_ce_n && !sram_oe_n && sram_we_n)
            sram_dq_in = model_mem.exists(int'(sram_addr)) ? model_mem[int'(sram_addr)] : BLANK;
        else
            sram_dq_in = 8'hEE;
    end

    // protocol monitor
    logic [16:0] p_addr;
    logic p_ce = 1, p_we = 1, p_oe = 1, pp_oe = 1, p_oe_en = 0, p_rv = 0;
    int oe_run = 0, we_run = 0;
    logic pre_we_setup = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (sram_addr != p_addr)
                check(p_ce && p_we && sram_we_n, "R5", "address moved under active strobes", 0, 1);
            if (sram_dq_oe && !sram_oe_n)
                check(0, "R4", "drivers on with output-enable low", 0, 1);
            if (!sram_we_n && !sram_oe_n)
                check(0, "R4", "output-enable low during write", 0, 1);
            if (!sram_oe_n && (sram_ce_n || !sram_we_n))
                check(0, "R2", "output-enable without read strobes", 0, 1);
            if (sram_dq_oe && !p_oe_en)
                check(p_oe && pp_oe, "R7", "drivers on too soon after read", 0, 1);
            if (rd_valid && p_rv)
                check(0, "R9", "rd_valid longer than one cycle", 2, 1);
            if (!sram_oe_n) oe_run++;
            else if (oe_run != 0) begin
                check(oe_run == TAA, "R2", "read strobe length", oe_run, TAA);
                oe_run = 0;
            end
            if (!sram_we_n) begin
                if (we_run == 0) pre_we_setup = !p_ce && p_we;
                we_run++;
            end else if (we_run != 0) begin
                check(we_run == PULSE, "R3", "write pulse length", we_run, PULSE);
                check(pre_we_setup, "R3", "setup cycle before pulse", 0, 1);
                we_run = 0;
            end
            if (rd_valid) begin
                if (exp_q.size() == 0) check(0, "R9", "unexpected rd_valid", 1, 0);
                else begin
                    logic [7:0] e;
                    int a;
                    e = exp_q.pop_front();
                    a = acc_q.pop_front();
                    check(rd_data == e, "R9", "read data", rd_data, e);
                    check(cyc - a == TAA, "R9", "read latency", cyc - a, TAA);
                end
            end
        end
        pp_oe = p_oe; p_oe = sram_oe_n; p_ce = sram_ce_n; p_we = sram_we_n;
        p_addr = sram_addr; p_oe_en = sram_dq_oe; p_rv = rd_valid;
    end

    // issue one request; called at a negedge, returns at the first idle negedge
    task automatic issue(bit wr, logic [16:0] a, logic [7:0] d);
        int n;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = ~a;
        req_wdata = ~d;
        req_write = ~wr;
        if (wr) ref_mem[int'(a)] = d;
        else begin
            exp_q.push_back(expect_at(a));
            acc_q.push_back(cyc);
        end
        n = 0;
        while (!req_ready) begin
            if (sram_addr != a) check(0, "R8", "address follows changed request", sram_addr, a);
            if (!sram_we_n && sram_dq_out != d) check(0, "R6", "write data", sram_dq_out, d);
            n++;
            @(negedge clk);
        end
        check(n == (wr ? PULSE + 1 : TAA + 1), "R8", "busy length", n, wr ? PULSE + 1 : TAA + 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        check(sram_ce_n && sram_we_n && sram_oe_n, "R1", "strobes after reset",
              {sram_ce_n, sram_we_n, sram_oe_n}, 7);
        check(!sram_dq_oe && !rd_valid, "R1", "drivers and rd_valid after reset",
              {sram_dq_oe, rd_valid}, 0);
        check(req_ready, "R1", "ready after reset", req_ready, 1);
        @(negedge clk);

        // directed corners
        issue(1'b0, 17'h00123, 8'h00);          // R9 unwritten byte
        issue(1'b1, 17'h00000, 8'h3C);          // R3 lowest address
        issue(1'b1, 17'h1FFFF, 8'hC3);          // R3 highest address
        issue(1'b0, 17'h00000, 8'h00);
        issue(1'b0, 17'h1FFFF, 8'h00);
        issue(1'b1, 17'h0AAAA, 8'hFF);          // write right after read: R7
        issue(1'b0, 17'h0AAAA, 8'h00);          // read right after write: R5
        issue(1'b1, 17'h0AAAA, 8'h00);          // overwrite
        issue(1'b0, 17'h0AAAA, 8'h00);
        repeat (3) @(negedge clk);

        // constrained random, back-to-back
        for (int i = 0; i < 400; i++) begin
            logic [16:0] a;
            a = {($urandom_range(0, 1) == 0) ? 9'h000 : 9'h1FF, 8'($urandom_range(0, 15))};
            issue(($urandom_range(0, 1) == 1), a, 8'($urandom));
            if ($urandom_range(0, 7) == 0) @(negedge clk);
        end

        repeat (TAA + 4) @(negedge clk);
        check(exp_q.size() == 0, "R9", "reads left without data", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule